// File: doc/BRIEF.md
# Five-Input Table Logic Cell with Registered Outputs

This block is one configurable logic cell. Five logic inputs form an address into a 32-bit truth table held in configuration storage, so any Boolean function of five variables costs exactly one table read and has the same combinational delay whatever function is stored. The table output drives two capture flip-flops. Both flip-flops share one clock, one clock enable and an asynchronous clear.

Each of the two outputs has its own configuration select bit. That bit steers the output either to the table result directly or to its own flip-flop. Before operation the table contents and both select bits are written through a parallel configuration port. The port accepts a write only while its enable is high.

Top module: `lut5_cell`

## Requirements
- R1: With an output's select bit at 0, that output equals table bit `cfg_lut[idx]` in the same cycle, where idx = `logic_in`, and bit 4 of `logic_in` (input A) is the most significant address bit down to bit 0 (input E).
- R2: The X and Y select bits act independently. X may show the registered value while Y shows the combinational value, and the reverse.
- R3: With a select bit at 1 and `clk_en` high, the output shows, after a rising clock edge, the table bit addressed just before that edge.
- R4: While `clk_en` is low, rising clock edges leave both flip-flops, and so the registered outputs, unchanged.
- R5: While `rd` is high, both flip-flops are 0 at once and stay 0 regardless of the clock and `clk_en`. A registered output therefore reads 0.
- R6: On a rising edge with `cfg_en` high, the table takes `cfg_lut` and the select bits take `cfg_sel_x`/`cfg_sel_y`. With `cfg_en` low, the configuration inputs are ignored.
- R7: A table holding only bit 31 set yields a five-input AND: the output is 1 only for `logic_in` = 5'b11111.
- R8: Writes to the configuration registers are not affected by `rd`. They are governed by `cfg_en` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for flip-flops and configuration |
| rd | input | 1 | Asynchronous clear of both flip-flops, active high |
| clk_en | input | 1 | Flip-flop clock enable |
| logic_in | input | 5 | Logic inputs A (bit 4) to E (bit 0) |
| cfg_en | input | 1 | Configuration write enable |
| cfg_lut | input | 32 | Truth table to load |
| cfg_sel_x | input | 1 | X source: 0 table, 1 flip-flop |
| cfg_sel_y | input | 1 | Y source: 0 table, 1 flip-flop |
| out_x | output | 1 | Output X |
| out_y | output | 1 | Output Y |

## Verification
Combinational results appear in the same cycle that `logic_in` changes. The bench drives at the falling edge and samples a nanosecond later, with no clock edge in between. Registered results and configuration writes take effect at the next rising edge, so the bench drives them at a falling edge and checks them at the following falling edge. The clear acts without waiting for a clock, and the bench checks it between two edges.

// File: rtl/lut5_cell.sv
module lut5_cell #(
  parameter int N_IN = 5
) (
  input  logic                 clk,
  input  logic                 rd,
  input  logic                 clk_en,
  input  logic [N_IN-1:0]      logic_in,
  input  logic                 cfg_en,
  input  logic [(1<<N_IN)-1:0] cfg_lut,
  input  logic                 cfg_sel_x,
  input  logic                 cfg_sel_y,
  output logic                 out_x,
  output logic                 out_y
);
  localparam int DEPTH = 1 << N_IN;

  logic [DEPTH-1:0] lut_q;
  logic             sel_x_q, sel_y_q;
  logic             q_x, q_y;
  logic             f_val, g_val;

  always_ff @(posedge clk) begin
    if (cfg_en) begin
      lut_q   <= cfg_lut;
      sel_x_q <= cfg_sel_x;
      sel_y_q <= cfg_sel_y;
    end
  end

  assign f_val = lut_q[logic_in];
  assign g_val = lut_q[logic_in];

  always_ff @(posedge clk or posedge rd) begin
    if (rd) begin
      q_x <= 1'b0;
      q_y <= 1'b0;
    end else if (clk_en) begin
      q_x <= f_val;
      q_y <= g_val;
    end
  end

  assign out_x = sel_x_q ? q_x : f_val;
  assign out_y = sel_y_q ? q_y : g_val;
endmodule

module lut5_cell_chk #(
  parameter int N_IN = 5
) (
  input logic                 clk,
  input logic                 rd,
  input logic                 clk_en,
  input logic [N_IN-1:0]      logic_in,
  input logic                 cfg_en,
  input logic [(1<<N_IN)-1:0] cfg_lut,
  input logic                 cfg_sel_x,
  input logic                 cfg_sel_y,
  input logic [(1<<N_IN)-1:0] lut_q,
  input logic                 sel_x_q,
  input logic                 sel_y_q,
  input logic                 q_x,
  input logic                 q_y
);
  assert_capture_R3: assert property (@(posedge clk) disable iff (rd)
    clk_en |=> (q_x == $past(lut_q[logic_in])) && (q_y == $past(lut_q[logic_in])));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rd)
    !clk_en |=> $stable(q_x) && $stable(q_y));

  assert_clear_R5: assert property (@(posedge clk)
    rd |-> (q_x == 1'b0) && (q_y == 1'b0));

  assert_cfg_load_R6: assert property (@(posedge clk)
    cfg_en |=> (lut_q == $past(cfg_lut)) && (sel_x_q == $past(cfg_sel_x))
               && (sel_y_q == $past(cfg_sel_y)));

  assert_cfg_keep_R6: assert property (@(posedge clk)
    !cfg_en |=> $stable(lut_q) && $stable(sel_x_q) && $stable(sel_y_q));
endmodule

bind lut5_cell lut5_cell_chk #(.N_IN(N_IN)) i_lut5_cell_chk (.*);

// File: tb/test_lut5_cell.sv
module test_lut5_cell;
  logic        clk = 1'b0;
  logic        rd = 1'b1;
  logic        clk_en = 1'b0;
  logic [4:0]  logic_in = '0;
  logic        cfg_en = 1'b0;
  logic [31:0] cfg_lut = '0;
  logic        cfg_sel_x = 1'b0;
  logic        cfg_sel_y = 1'b0;
  logic        out_x, out_y;

  int checks = 0;
  int fails = 0;
  logic [31:0] tbl;

  always #5 clk = ~clk;

  lut5_cell i_lut5_cell (
    .clk(clk), .rd(rd), .clk_en(clk_en), .logic_in(logic_in),
    .cfg_en(cfg_en), .cfg_lut(cfg_lut), .cfg_sel_x(cfg_sel_x),
    .cfg_sel_y(cfg_sel_y), .out_x(out_x), .out_y(out_y)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] t, input logic sx, input logic sy);
    @(negedge clk);
    cfg_en = 1'b1; cfg_lut = t; cfg_sel_x = sx; cfg_sel_y = sy;
    @(negedge clk);
    cfg_en = 1'b0;
    tbl = t;
  endtask

  task automatic t_reset;
    load(32'hFFFF_FFFF, 1'b1, 1'b1);
    clk_en = 1'b1;
    @(negedge clk); #1;
    chk(out_x, 1'b0, "R5 reset X");
    chk(out_y, 1'b0, "R5 reset Y");
  endtask

  task automatic comb_sweep(input string req);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      logic_in = a[4:0];
      #1;
      chk(out_x, tbl[a], req);
      chk(out_y, tbl[a], req);
    end
  endtask

  task automatic t_comb;
    load($urandom(), 1'b0, 1'b0);      comb_sweep("R1 random");
    load(32'hAAAA_5555, 1'b0, 1'b0);   comb_sweep("R1 pattern");
    load(32'h0000_FFFF, 1'b0, 1'b0);   comb_sweep("R1 msb A");
  endtask

  task automatic t_and;
    load(32'h8000_0000, 1'b0, 1'b0);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      logic_in = a[4:0];
      #1;
      chk(out_x, (a == 31), "R7 and5");
    end
  endtask

  task automatic t_reg;
    load($urandom(), 1'b1, 1'b1);
    clk_en = 1'b1;
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      logic_in = a[4:0];
      @(negedge clk); #1;
      chk(out_x, tbl[a], "R3 reg X");
      chk(out_y, tbl[a], "R3 reg Y");
    end
  endtask

  task automatic t_mixed;
    load(32'h0000_0001, 1'b1, 1'b0);
    clk_en = 1'b1;
    @(negedge clk); logic_in = 5'd0;
    @(negedge clk); logic_in = 5'd1; #1;
    chk(out_y, 1'b0, "R2 Y comb now");
    chk(out_x, 1'b1, "R2 X still registered");
    @(negedge clk); #1;
    chk(out_x, 1'b0, "R2 X after edge");
    load(32'h0000_0001, 1'b0, 1'b1);
    logic_in = 5'd0; #1;
    chk(out_x, 1'b1, "R2 X comb now");
    chk(out_y, 1'b0, "R2 Y still registered");
  endtask

  task automatic t_hold;
    load(32'h0000_0002, 1'b1, 1'b1);
    clk_en = 1'b1;
    @(negedge clk); logic_in = 5'd1;
    @(negedge clk); clk_en = 1'b0; logic_in = 5'd0;
    @(negedge clk); @(negedge clk); #1;
    chk(out_x, 1'b1, "R4 hold X");
    chk(out_y, 1'b1, "R4 hold Y");
    clk_en = 1'b1;
    @(negedge clk); #1;
    chk(out_x, 1'b0, "R4 resume X");
  endtask

  task automatic t_async;
    load(32'hFFFF_FFFF, 1'b1, 1'b1);
    clk_en = 1'b1;
    @(negedge clk); #1;
    chk(out_x, 1'b1, "R5 pre-clear X");
    #1 rd = 1'b1; #1;
    chk(out_x, 1'b0, "R5 async clear X");
    chk(out_y, 1'b0, "R5 async clear Y");
    @(negedge clk); @(negedge clk); #1;
    chk(out_x, 1'b0, "R5 clear held X");
    load(32'h0000_0000, 1'b0, 1'b0);
    load(32'h0000_0008, 1'b0, 1'b1);
    logic_in = 5'd3; #1;
    chk(out_x, 1'b1, "R8 cfg write during rd");
    chk(out_y, 1'b0, "R8 Y registered under rd");
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_cfg_ignore;
    load(32'h1234_5678, 1'b0, 1'b0);
    @(negedge clk);
    cfg_lut = ~32'h1234_5678; cfg_sel_x = 1'b1; cfg_sel_y = 1'b1;
    @(negedge clk); @(negedge clk);
    comb_sweep("R6 write ignored");
    load(32'hCAFE_0F0F, 1'b0, 1'b0);
    comb_sweep("R6 write accepted");
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    @(negedge clk); rd = 1'b0;
    t_comb;
    t_and;
    t_reg;
    t_mixed;
    t_hold;
    t_async;
    t_cfg_ignore;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule